// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a small 8-bit accumulator machine with hardwired control and a 64-byte address space. Each 8-bit instruction word carries a two-bit operation code in its upper bits and a six-bit memory address in its lower bits. The processor drives an address and a read strobe to an external memory whose data returns combinationally in the same cycle, and fetches and executes one instruction at a time.

Inside, an address register, a program counter, a data register, an accumulator and a two-bit instruction register exchange values over one internal 8-bit bus. Exactly one source is enabled onto that bus at a time. The program counter and the accumulator each have their own increment input, and a two-function arithmetic unit takes the accumulator directly and the data register through the bus. The accumulator value is brought out on a port so that the result of a program can be observed.

Top module: `acc_cpu4`

## Requirements
- R1: A synchronous active-high reset clears the program counter, address register, data register, accumulator and instruction register, and leaves the machine at the first fetch step, with `acc` = 0x00, `mem_rd` = 0 and `mem_addr` = 0 in the cycle after reset.
- R2: Each instruction is fetched in three cycles: the address register is loaded from the program counter, memory is read at that address while the program counter increments, then the opcode (bits 7:6) and the operand address (bits 5:0) are split off. The first fetch read after reset is at address 0, in the second cycle.
- R3: Opcode 00 reads the byte at the operand address (in the cycle after the fetch) and adds it to the accumulator modulo 256, with no carry kept.
- R4: Opcode 01 reads the byte at the operand address and replaces the accumulator with the bitwise AND of the two.
- R5: Opcode 10 loads the program counter with bits 5:0 of the instruction; the next fetch reads that address.
- R6: Opcode 11 increments the accumulator by one, wrapping 0xFF to 0x00, without any memory read.
- R7: The program counter wraps from 63 to 0, so the fetch after address 63 reads address 0.
- R8: `mem_rd` is high only in the instruction read and operand read cycles; it is never high in two consecutive cycles, and exactly one read occurs per jump or increment instruction.
- R9: Add and AND instructions take five cycles in total and jump and increment take four; the accumulator changes on the clock edge that ends the last cycle of an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 6 | Memory address, driven from the address register |
| mem_rdata | input | 8 | Memory read data, sampled on the edge ending a read cycle |
| mem_rd | output | 1 | Read strobe, high in cycles that read memory |
| acc | output | 8 | Current accumulator value |

## Verification
A wrong program counter or address register shows at once on `mem_addr` as a read from the wrong location, within one instruction of the fault, so the bench logs every read address and compares it against the sequence each short program must produce. A wrong sequencer state shows as a read strobe in the wrong cycle or as an instruction that is one cycle too long or short, which moves the accumulator update away from the exact edge the bench samples. A faulty arithmetic path or data register only shows on `acc` at the end of an add, AND or increment, so each program ends with a known value and also checks carry loss and wrap.

// File: rtl/acc_cpu4.sv
module acc_cpu4 #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic [DW-1:0] acc
);

  localparam int OW = DW - AW;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_ADD1, S_ADD2, S_AND1, S_AND2, S_JMP1, S_INC1
  } state_t;

  state_t          st, st_nx;
  logic [AW-1:0]   ar, pc;
  logic [DW-1:0]   dr, ac;
  logic [OW-1:0]   ir;
  logic [DW-1:0]   bus, alu_y;

  logic pc_bus, dr_bus, mem_bus;
  logic ar_ld, pc_ld, pc_inc, dr_ld, ac_ld, ac_inc, ir_ld;

  assign pc_bus  = (st == S_F1);
  assign mem_bus = (st == S_F2) || (st == S_ADD1) || (st == S_AND1);
  assign dr_bus  = (st == S_F3) || (st == S_ADD2) || (st == S_AND2) || (st == S_JMP1);

  assign ar_ld  = (st == S_F1) || (st == S_F3);
  assign pc_inc = (st == S_F2);
  assign pc_ld  = (st == S_JMP1);
  assign dr_ld  = mem_bus;
  assign ir_ld  = (st == S_F3);
  assign ac_ld  = (st == S_ADD2) || (st == S_AND2);
  assign ac_inc = (st == S_INC1);

  always_comb begin
    bus = '0;
    if (pc_bus)  bus[AW-1:0] = pc;
    if (dr_bus)  bus = dr;
    if (mem_bus) bus = mem_rdata;
  end

  assign alu_y = ir[0] ? (ac & bus) : (ac + bus);

  always_comb begin
    st_nx = S_F1;
    case (st)
      S_F1: st_nx = S_F2;
      S_F2: st_nx = S_F3;
      S_F3: begin
        case (bus[DW-1 -: OW])
          2'b00:   st_nx = S_ADD1;
          2'b01:   st_nx = S_AND1;
          2'b10:   st_nx = S_JMP1;
          default: st_nx = S_INC1;
        endcase
      end
      S_ADD1: st_nx = S_ADD2;
      S_AND1: st_nx = S_AND2;
      default: st_nx = S_F1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_F1;
      ar <= '0;
      pc <= '0;
      dr <= '0;
      ac <= '0;
      ir <= '0;
    end else begin
      st <= st_nx;
      if (ar_ld)       ar <= bus[AW-1:0];
      if (pc_ld)       pc <= bus[AW-1:0];
      else if (pc_inc) pc <= pc + 1'b1;
      if (dr_ld)       dr <= bus;
      if (ir_ld)       ir <= bus[DW-1 -: OW];
      if (ac_ld)       ac <= alu_y;
      else if (ac_inc) ac <= ac + 1'b1;
    end
  end

  assign mem_addr = ar;
  assign mem_rd   = mem_bus;
  assign acc      = ac;

endmodule

module acc_cpu4_props #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic [DW-1:0] acc,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] dr,
  input logic [3:0]    st
);

  localparam logic [3:0] F2 = 4'd1, ADD2 = 4'd4, JMP1 = 4'd7, INC1 = 4'd8;

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (acc == '0 && !mem_rd && pc == '0));

  a_r2_pc_advance: assert property (@(posedge clk) disable iff (rst)
    (st == F2) |=> (pc == AW'($past(pc) + 1'b1)));

  a_r3_add_wraps: assert property (@(posedge clk) disable iff (rst)
    (st == ADD2) |=> (acc == DW'($past(acc) + $past(dr))));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    (st == JMP1) |=> (pc == $past(dr[AW-1:0])));

  a_r6_inc_wraps: assert property (@(posedge clk) disable iff (rst)
    (st == INC1) |=> (acc == DW'($past(acc) + 1'b1)));

  a_r8_no_back_to_back_reads: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

endmodule

bind acc_cpu4 acc_cpu4_props #(.DW(DW), .AW(AW)) u_props (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .acc(acc),
  .pc(pc), .dr(dr), .st(st)
);

// File: tb/test_acc_cpu4.sv
module test_acc_cpu4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] mem_addr;
  logic [7:0] mem_rdata;
  logic       mem_rd;
  logic [7:0] acc;

  logic [7:0] mem [64];
  logic [5:0] rlog [256];
  int nlog = 0;
  int base = 0;
  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  acc_cpu4 i_acc_cpu4 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .acc(acc)
  );

  assign mem_rdata = mem[mem_addr];

  always @(negedge clk) begin
    if (!rst && mem_rd && nlog < 256) begin
      rlog[nlog] = mem_addr;
      nlog = nlog + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  task automatic start();
    rst = 1'b1;
    tick(2);
    base = nlog;
    rst = 1'b0;
  endtask

  task automatic chk_read(input string req, input int idx, input logic [5:0] exp);
    if (base + idx < nlog) chk(req, {10'd0, rlog[base + idx]}, {10'd0, exp});
    else chk(req, 16'hFFFF, {10'd0, exp});
  endtask

  task automatic t_reset();
    clear_mem();
    mem[0] = 8'hC0;
    mem[1] = 8'h80;
    start();
    tick(8);
    rst = 1'b1;
    tick(1);
    chk("R1 acc after reset", {8'd0, acc}, 16'h0000);
    chk("R1 mem_rd after reset", {15'd0, mem_rd}, 16'h0000);
    chk("R1 mem_addr after reset", {10'd0, mem_addr}, 16'h0000);
    tick(1);
    base = nlog;
    rst = 1'b0;
    chk("R2 first cycle no read", {15'd0, mem_rd}, 16'h0000);
    tick(1);
    chk("R2 fetch read strobe", {15'd0, mem_rd}, 16'h0001);
    chk("R2 fetch from address 0", {10'd0, mem_addr}, 16'h0000);
  endtask

  task automatic t_add();
    clear_mem();
    mem[0] = 8'h0A;
    mem[1] = 8'h0B;
    mem[2] = 8'h82;
    mem[10] = 8'hF0;
    mem[11] = 8'h25;
    start();
    tick(3);
    chk("R3 operand read strobe", {15'd0, mem_rd}, 16'h0001);
    chk("R3 operand address", {10'd0, mem_addr}, 16'h000A);
    tick(1);
    chk("R9 add not done after four cycles", {8'd0, acc}, 16'h0000);
    tick(1);
    chk("R3 add result", {8'd0, acc}, 16'h00F0);
    tick(5);
    chk("R3 add modulo 256", {8'd0, acc}, 16'h0015);
    chk_read("R2 read order 0", 0, 6'd0);
    chk_read("R2 read order 1", 1, 6'd10);
    chk_read("R2 read order 2", 2, 6'd1);
    chk_read("R2 read order 3", 3, 6'd11);
  endtask

  task automatic t_and();
    clear_mem();
    mem[0] = 8'h14;
    mem[1] = 8'h55;
    mem[2] = 8'h82;
    mem[20] = 8'hCA;
    mem[21] = 8'h5F;
    start();
    tick(9);
    chk("R9 and not done after nine cycles", {8'd0, acc}, 16'h00CA);
    tick(1);
    chk("R4 and result", {8'd0, acc}, 16'h004A);
    chk_read("R4 operand read", 3, 6'd21);
  endtask

  task automatic t_inc();
    clear_mem();
    mem[0] = 8'h05;
    mem[1] = 8'hC0;
    mem[2] = 8'hC0;
    mem[3] = 8'h83;
    mem[5] = 8'hFE;
    start();
    tick(8);
    chk("R9 inc not done after three cycles", {8'd0, acc}, 16'h00FE);
    tick(1);
    chk("R6 inc result", {8'd0, acc}, 16'h00FF);
    tick(4);
    chk("R6 inc wraps to zero", {8'd0, acc}, 16'h0000);
    chk("R8 no operand read for inc", nlog - base, 16'd4);
    chk_read("R6 fetch after inc", 3, 6'd2);
  endtask

  task automatic t_jmp();
    clear_mem();
    mem[0] = 8'hBE;
    mem[62] = 8'hC0;
    mem[63] = 8'hC0;
    start();
    tick(24);
    chk("R5 R7 acc after two loops", {8'd0, acc}, 16'h0004);
    chk("R8 one read per jump or inc", nlog - base, 16'd6);
    chk_read("R5 fetch at jump target", 1, 6'd62);
    chk_read("R7 pc step to 63", 2, 6'd63);
    chk_read("R7 pc wraps to 0", 3, 6'd0);
    chk_read("R5 second jump", 4, 6'd62);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_add();
    t_and();
    t_inc();
    t_jmp();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule